// File: doc/BRIEF.md
# Saturating rounding vector shifter

This unit shifts every element of a 64-bit vector by its own signed amount. A positive amount shifts left and a negative amount shifts right. The elements can be 8, 16, 32 or 64 bits wide. There are three operating modes:

- signed operand with signed result;
- unsigned operand with unsigned result;
- signed operand with unsigned result.

Two enables give independent control. One enables rounding on right shifts. The other enables clamping to the result range when a left shift overflows. A sticky flag records that some lane has clamped since the flag was last cleared. Each lane takes its shift amount from the low byte of the matching element of a second vector, read as a signed value.

Operands come in on a valid/ready stream and results leave on another, through one output register. A beat is taken when `in_valid` and `in_ready` are both high. Its result shows up on `out_data` with `out_valid` high at the next clock edge. While `out_valid` is high and `out_ready` is low, the result holds steady and `in_ready` stays low, so back-pressure from downstream stops intake. When `out_ready` is high, the register can empty and take a new beat on the same edge. That gives one beat per cycle under steady flow. The size, mode and enables travel with the beat and are sampled only when the beat is accepted. The flag clear is a plain control input.

Top module: `vec_sat_shifter`

## Requirements
- R1: `in_size` selects the lane width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. `in_mode` selects the mode: 0 is signed to signed, 1 is unsigned to unsigned, 2 is signed to unsigned, and 3 behaves as 0. Each lane is computed independently. A lane's shift amount is bits [7:0] of its element of `in_shift`, read as two's complement. The higher bits of that element have no effect.
- R2: For a left shift by less than the lane width with `in_sat` low, the result is the shifted value truncated to the lane width, and the flag is not set.
- R3: In signed modes a right shift is arithmetic. If the amount is at least the lane width, the result is 0 when rounding is on. When rounding is off it is the sign fill: all ones for a negative lane, otherwise 0.
- R4: In unsigned mode a right shift is logical. The result is 0 when the amount is at or below -(width + round). So with rounding on, a shift of exactly -width returns the lane's top bit.
- R5: A rounding right shift by n first shifts right by n-1, giving t. The result is (t shifted right by one) plus bit 0 of t.
- R6: In signed mode with `in_sat` high, a left shift by less than the width saturates when the value does not fit the signed lane range. The result is then the most positive value for a non-negative lane, otherwise the most negative value, and the flag is set.
- R7: In the unsigned-result modes with `in_sat` high, a left shift that loses any set bit gives all ones and sets the flag.
- R8: A left shift by the width or more gives 0 for a zero lane. For a non-zero lane it gives the saturation value and sets the flag when `in_sat` is high, and gives 0 when `in_sat` is low.
- R9: In mode 2 with `in_sat` high, a negative lane gives 0 and sets the flag. Otherwise mode 2 follows the unsigned rules, reading the lane bits as unsigned.
- R10: `sat_flag` is set by an accepted beat in which any lane saturates. It stays set until a cycle with `flag_clear` high clears it. If the clear and a saturating beat fall in the same cycle, the flag ends set.
- R11: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. An accepted beat's result appears one edge later. A stalled result holds `out_data` stable.
- R12: After reset, `out_valid` and `sat_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat is valid |
| in_ready | output | 1 | Unit can take a beat |
| in_data | input | 64 | Operand vector |
| in_shift | input | 64 | Per-lane shift amount vector (low byte of each element) |
| in_size | input | 2 | Lane width select |
| in_mode | input | 2 | Signedness mode |
| in_round | input | 1 | Round right shifts |
| in_sat | input | 1 | Saturate left-shift overflow |
| flag_clear | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result beat is valid |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 64 | Result vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Hand-picked byte lanes cover specific boundaries:
- values just inside and just outside the signed range (0x40, 0xC0, 0xBF);
- right shifts of exactly the width and one more, with and without rounding, which separate the signed and unsigned cut-off rules;
- odd negative values that round differently from plain truncation.

A 16-bit case puts a non-zero upper byte in the shift element to show that only the low byte counts. Vectors made from a shift register pattern are run at every width and mode against a range-based model. These show whether lanes leak into one another and whether the width mux selects the right lane set. Stalls with a second beat waiting, and a clear issued together with a saturating beat, separate correct flag and hand-off timing from off-by-one-cycle behaviour.

// File: rtl/vss_pkg.sv
package vss_pkg;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } vss_size_e;

  typedef enum logic [1:0] {
    MD_SS  = 2'd0,
    MD_UU  = 2'd1,
    MD_SU  = 2'd2,
    MD_ALT = 2'd3
  } vss_mode_e;

  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE_W = 8;

endpackage

// File: rtl/vss_lane.sv
module vss_lane
  import vss_pkg::*;
#(
  parameter int W    = 8,
  parameter int SH_W = 8
) (
  input  logic [W-1:0]    src,
  input  logic [SH_W-1:0] sh,
  input  vss_mode_e       mode,
  input  logic            rnd,
  input  logic            sat_en,
  output logic [W-1:0]    res,
  output logic            sat
);
  localparam int WW = 2 * W;

  logic              sgn_in;
  logic              neg;
  logic [W-1:0]      sat_val;
  logic [WW-1:0]     wide;
  logic              fits;
  logic signed [W-1:0] t_s;
  logic signed [W-1:0] th_s;
  logic [W-1:0]      t_u;
  int                sh_i;
  int                n;

  always_comb begin
    sgn_in  = (mode == MD_SS) || (mode == MD_ALT);
    neg     = src[W-1];
    sat_val = sgn_in ? (neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}})
                     : {W{1'b1}};
    sh_i    = int'($signed(sh));
    n       = -sh_i;
    wide    = '0;
    fits    = 1'b1;
    t_s     = '0;
    th_s    = '0;
    t_u     = '0;
    res     = '0;
    sat     = 1'b0;
    if ((mode == MD_SU) && sat_en && neg) begin
      res = '0;
      sat = 1'b1;
    end else if (sh_i < 0) begin
      if (sgn_in) begin
        if (n >= W) begin
          res = rnd ? '0 : {W{neg}};
        end else if (rnd) begin
          t_s  = $signed(src) >>> (n - 1);
          th_s = t_s >>> 1;
          res  = th_s + {{(W-1){1'b0}}, t_s[0]};
        end else begin
          res = $signed(src) >>> n;
        end
      end else begin
        if (n >= W + int'(rnd)) begin
          res = '0;
        end else if (rnd) begin
          t_u = src >> (n - 1);
          res = (t_u >> 1) + {{(W-1){1'b0}}, t_u[0]};
        end else begin
          res = src >> n;
        end
      end
    end else if (sh_i < W) begin
      wide = sgn_in ? {{W{neg}}, src} : {{W{1'b0}}, src};
      wide = wide << sh_i;
      fits = sgn_in ? ((&wide[WW-1:W-1]) || (~|wide[WW-1:W-1]))
                    : (~|wide[WW-1:W]);
      if (!sat_en || fits) begin
        res = wide[W-1:0];
      end else begin
        res = sat_val;
        sat = 1'b1;
      end
    end else begin
      if ((src == '0) || !sat_en) begin
        res = '0;
      end else begin
        res = sat_val;
        sat = 1'b1;
      end
    end
  end

  // R2
  always_comb begin
    if (!sat_en) begin
      lane_nosat_chk: assert (!sat);
    end
  end

endmodule

// File: rtl/vss_size_group.sv
module vss_size_group
  import vss_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int W     = 8,
  parameter int SH_W  = 8
) (
  input  logic [VEC_W-1:0]              src_vec,
  input  logic [(VEC_W/W)*SH_W-1:0]     sh_pk,
  input  vss_mode_e                     mode,
  input  logic                          rnd,
  input  logic                          sat_en,
  output logic [VEC_W-1:0]              res_vec,
  output logic                          sat_any
);
  localparam int NL = VEC_W / W;

  logic [NL-1:0] lane_sat;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    vss_lane #(.W(W), .SH_W(SH_W)) u_lane (
      .src    (src_vec[i*W +: W]),
      .sh     (sh_pk[i*SH_W +: SH_W]),
      .mode   (mode),
      .rnd    (rnd),
      .sat_en (sat_en),
      .res    (res_vec[i*W +: W]),
      .sat    (lane_sat[i])
    );
  end

  assign sat_any = |lane_sat;

endmodule

// File: rtl/vss_lane_array.sv
module vss_lane_array
  import vss_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int SH_W  = 8
) (
  input  logic [VEC_W-1:0] data,
  input  logic [VEC_W-1:0] shift,
  input  vss_size_e        size,
  input  vss_mode_e        mode,
  input  logic             rnd,
  input  logic             sat_en,
  output logic [VEC_W-1:0] res,
  output logic             sat_any
);
  logic [VEC_W-1:0] grp_res [NUM_SIZES];
  logic             grp_sat [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int W  = MIN_LANE_W << k;
    localparam int NL = VEC_W / W;
    logic [NL*SH_W-1:0] sh_pk;

    for (genvar j = 0; j < NL; j++) begin : g_pack
      assign sh_pk[j*SH_W +: SH_W] = shift[j*W +: SH_W];
    end

    vss_size_group #(.VEC_W(VEC_W), .W(W), .SH_W(SH_W)) u_grp (
      .src_vec (data),
      .sh_pk   (sh_pk),
      .mode    (mode),
      .rnd     (rnd),
      .sat_en  (sat_en),
      .res_vec (grp_res[k]),
      .sat_any (grp_sat[k])
    );
  end

  always_comb begin
    res     = grp_res[int'(size)];
    sat_any = grp_sat[int'(size)];
  end

endmodule

// File: rtl/vss_out_stage.sv
module vss_out_stage #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] next_data,
  input  logic          next_sat,
  input  logic          flag_clear,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          sat_flag
);
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      sat_flag  <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept)   out_data  <= next_data;
      sat_flag <= (sat_flag && !flag_clear) || (accept && next_sat);
    end
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !flag_clear |=> sat_flag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clear && !(in_valid && in_ready) |=> !sat_flag);

endmodule

// File: rtl/vec_sat_shifter.sv
module vec_sat_shifter
  import vss_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int SH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_data,
  input  logic [VEC_W-1:0] in_shift,
  input  logic [1:0]       in_size,
  input  logic [1:0]       in_mode,
  input  logic             in_round,
  input  logic             in_sat,
  input  logic             flag_clear,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic             sat_flag
);
  logic [VEC_W-1:0] comb_res;
  logic             comb_sat;

  vss_lane_array #(.VEC_W(VEC_W), .SH_W(SH_W)) u_array (
    .data    (in_data),
    .shift   (in_shift),
    .size    (vss_size_e'(in_size)),
    .mode    (vss_mode_e'(in_mode)),
    .rnd     (in_round),
    .sat_en  (in_sat),
    .res     (comb_res),
    .sat_any (comb_sat)
  );

  vss_out_stage #(.DW(VEC_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .next_data  (comb_res),
    .next_sat   (comb_sat),
    .flag_clear (flag_clear),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .sat_flag   (sat_flag)
  );

  // R2
  wrap_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_sat && !flag_clear && !sat_flag |=> !sat_flag);

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !sat_flag);

endmodule

// File: tb/test_vec_sat_shifter.sv
`timescale 1ns/1ps
module test_vec_sat_shifter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_round, in_sat, flag_clear;
  logic [63:0] in_data, in_shift, out_data;
  logic [1:0]  in_size, in_mode;
  logic        out_valid, out_ready, sat_flag;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  exp_flag = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  vec_sat_shifter i_vec_sat_shifter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_shift(in_shift), .in_size(in_size), .in_mode(in_mode),
    .in_round(in_round), .in_sat(in_sat), .flag_clear(flag_clear),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sat_flag(sat_flag)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] d, input logic [63:0] sh,
                                input logic [1:0] sz, input logic [1:0] md,
                                input logic rn, input logic st,
                                output logic [63:0] r, output logic f);
    int w, nl, s, n;
    logic [63:0] mask, src;
    logic signed [129:0] x, v, lo, hi, rr, t, th, satv;
    bit sgn, neg, ls;
    w = 8 << sz;
    nl = 64 / w;
    r = '0;
    f = 1'b0;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    sgn = (md == 2'd0) || (md == 2'd3);
    for (int i = 0; i < nl; i++) begin
      src = (d >> (i * w)) & mask;
      s = int'($signed(sh[i*w +: 8]));
      neg = src[w-1];
      x = $signed({66'd0, src});
      if (sgn && neg) x = x - (130'sd1 <<< w);
      lo = sgn ? -(130'sd1 <<< (w - 1)) : 130'sd0;
      hi = sgn ? ((130'sd1 <<< (w - 1)) - 130'sd1) : ((130'sd1 <<< w) - 130'sd1);
      satv = (x < 0) ? lo : hi;
      ls = 1'b0;
      rr = 130'sd0;
      if (md == 2'd2 && st && neg) begin
        ls = 1'b1;
      end else if (s < 0) begin
        n = -s;
        if (sgn && n >= w) rr = rn ? 130'sd0 : ((x < 0) ? -130'sd1 : 130'sd0);
        else if (!sgn && n >= w + int'(rn)) rr = 130'sd0;
        else if (rn) begin
          t = x >>> (n - 1);
          th = t >>> 1;
          rr = th + (t[0] ? 130'sd1 : 130'sd0);
        end else rr = x >>> n;
      end else if (s < w) begin
        v = x <<< s;
        if (!st || (v >= lo && v <= hi)) rr = v;
        else begin rr = satv; ls = 1'b1; end
      end else if (x == 0 || !st) begin
        rr = 130'sd0;
      end else begin
        rr = satv;
        ls = 1'b1;
      end
      r = r | ((64'(rr) & mask) << (i * w));
      f = f | ls;
    end
  endfunction

  task automatic run_exp(input logic [63:0] d, input logic [63:0] s,
                         input logic [1:0] sz, input logic [1:0] md,
                         input logic rn, input logic st,
                         input logic [63:0] ed, input logic ef, input string req);
    @(negedge clk);
    in_data = d; in_shift = s; in_size = sz; in_mode = md;
    in_round = rn; in_sat = st; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_flag = exp_flag | ef;
    check(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
    check(out_data == ed, req, out_data, ed);
    check(sat_flag == exp_flag, req, 64'(sat_flag), 64'(exp_flag));
  endtask

  task automatic run_model(input logic [63:0] d, input logic [63:0] s,
                           input logic [1:0] sz, input logic [1:0] md,
                           input logic rn, input logic st, input string req);
    logic [63:0] ed;
    logic ef;
    model(d, s, sz, md, rn, st, ed, ef);
    run_exp(d, s, sz, md, rn, st, ed, ef, req);
  endtask

  task automatic do_clear(input string req);
    @(negedge clk);
    flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0;
    exp_flag = 1'b0;
    check(sat_flag == 1'b0, req, 64'(sat_flag), 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R12 out_valid in reset", 64'(out_valid), 64'd0);
    check(sat_flag == 1'b0, "R12 flag in reset", 64'(sat_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R12 idle after reset",
          {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  task automatic t_wrap;
    run_exp(64'h40, 64'h01, 2'd0, 2'd0, 1'b0, 1'b0, 64'h80, 1'b0, "R2 signed wrap");
    run_exp(64'hF0, 64'h04, 2'd0, 2'd1, 1'b0, 1'b0, 64'h00, 1'b0, "R2 unsigned wrap");
    run_model(64'h7FFF_0001_8000_4000, 64'h0002_0003_0001_0001, 2'd1, 2'd0, 1'b0, 1'b0,
              "R2 16-bit wrap");
  endtask

  task automatic t_size_lanes;
    logic [63:0] d, s, r;
    run_exp(64'h11, 64'h0102, 2'd1, 2'd1, 1'b0, 1'b0, 64'h44, 1'b0,
            "R1 only low byte of shift element");
    r = 64'hACE1_2345_6789_BEEF;
    for (int k = 0; k < 16; k++) begin
      d = r;
      r = {r[62:0], r[63] ^ r[62] ^ r[60] ^ r[59]};
      r = {r[62:0], r[63] ^ r[62] ^ r[60] ^ r[59]};
      s = r & 64'h8787_8787_8787_8787;
      for (int b = 0; b < 8; b++) if (s[b*8+7]) s[b*8 +: 8] = s[b*8 +: 8] | 8'h78;
      run_model(d, s, 2'(k % 4), 2'((k / 4) % 4), 1'(k % 3 == 0), 1'(k % 2),
                "R1 lane independence pattern");
    end
    do_clear("R10 clear after pattern");
  endtask

  task automatic t_signed_right;
    run_exp(64'h90, 64'hFC, 2'd0, 2'd0, 1'b0, 1'b0, 64'hF9, 1'b0, "R3 arithmetic right");
    run_exp(64'h90, 64'hF8, 2'd0, 2'd0, 1'b0, 1'b0, 64'hFF, 1'b0, "R3 sign fill at width");
    run_exp(64'h90, 64'hF8, 2'd0, 2'd0, 1'b1, 1'b0, 64'h00, 1'b0, "R3 round at width gives 0");
    run_exp(64'h70, 64'h80, 2'd0, 2'd3, 1'b0, 1'b0, 64'h00, 1'b0, "R3 mode 3 positive fill");
  endtask

  task automatic t_unsigned_right;
    run_exp(64'h90, 64'hFC, 2'd0, 2'd1, 1'b0, 1'b0, 64'h09, 1'b0, "R4 logical right");
    run_exp(64'h90, 64'hF8, 2'd0, 2'd1, 1'b1, 1'b0, 64'h01, 1'b0, "R4 round at -width");
    run_exp(64'h90, 64'hF8, 2'd0, 2'd1, 1'b0, 1'b0, 64'h00, 1'b0, "R4 no round at -width");
    run_exp(64'h90, 64'hF7, 2'd0, 2'd1, 1'b1, 1'b0, 64'h00, 1'b0, "R4 round beyond width");
  endtask

  task automatic t_round;
    run_exp(64'h17, 64'hFE, 2'd0, 2'd0, 1'b1, 1'b0, 64'h06, 1'b0, "R5 round positive");
    run_exp(64'hEB, 64'hFE, 2'd0, 2'd0, 1'b1, 1'b0, 64'hFB, 1'b0, "R5 round negative");
    run_exp(64'hEB, 64'hFE, 2'd0, 2'd0, 1'b0, 1'b0, 64'hFA, 1'b0, "R5 truncate negative");
    run_exp(64'hFF, 64'hFF, 2'd0, 2'd1, 1'b1, 1'b0, 64'h80, 1'b0, "R5 unsigned round by one");
  endtask

  task automatic t_signed_sat;
    run_exp(64'hC0, 64'h01, 2'd0, 2'd0, 1'b0, 1'b1, 64'h80, 1'b0, "R6 fits at min");
    run_exp(64'h40, 64'h01, 2'd0, 2'd0, 1'b0, 1'b1, 64'h7F, 1'b1, "R6 saturate max");
    do_clear("R10 clear");
    run_exp(64'hBF, 64'h01, 2'd0, 2'd0, 1'b0, 1'b1, 64'h80, 1'b1, "R6 saturate min");
    run_exp(64'h4000_0000_0000_0000, 64'h01, 2'd3, 2'd0, 1'b0, 1'b1,
            64'h7FFF_FFFF_FFFF_FFFF, 1'b1, "R6 64-bit saturate");
    do_clear("R10 clear");
  endtask

  task automatic t_unsigned_sat;
    run_exp(64'h7F, 64'h01, 2'd0, 2'd1, 1'b0, 1'b1, 64'hFE, 1'b0, "R7 fits");
    run_exp(64'h80, 64'h01, 2'd0, 2'd1, 1'b0, 1'b1, 64'hFF, 1'b1, "R7 saturate");
    do_clear("R10 clear");
  endtask

  task automatic t_big_left;
    run_exp(64'h00, 64'h08, 2'd0, 2'd0, 1'b0, 1'b1, 64'h00, 1'b0, "R8 zero source");
    run_exp(64'h01, 64'h7F, 2'd0, 2'd0, 1'b0, 1'b0, 64'h00, 1'b0, "R8 no sat gives 0");
    run_exp(64'h80, 64'h08, 2'd0, 2'd0, 1'b0, 1'b1, 64'h80, 1'b1, "R8 signed sat min");
    run_exp(64'h01, 64'h08, 2'd0, 2'd1, 1'b0, 1'b1, 64'hFF, 1'b1, "R8 unsigned sat");
    do_clear("R10 clear");
  endtask

  task automatic t_s2u;
    run_exp(64'h05, 64'h01, 2'd0, 2'd2, 1'b0, 1'b1, 64'h0A, 1'b0, "R9 positive shift");
    run_exp(64'h90, 64'hFF, 2'd0, 2'd2, 1'b0, 1'b0, 64'h48, 1'b0, "R9 no sat is unsigned");
    run_exp(64'h80, 64'h00, 2'd0, 2'd2, 1'b0, 1'b1, 64'h00, 1'b1, "R9 negative gives 0");
    do_clear("R10 clear");
    run_exp(64'h40, 64'h02, 2'd0, 2'd2, 1'b0, 1'b1, 64'hFF, 1'b1, "R9 unsigned sat");
  endtask

  task automatic t_sticky;
    run_exp(64'h01, 64'h01, 2'd0, 2'd0, 1'b0, 1'b1, 64'h02, 1'b0, "R10 flag sticks");
    @(negedge clk);
    in_data = 64'h40; in_shift = 64'h01; in_size = 2'd0; in_mode = 2'd0;
    in_round = 1'b0; in_sat = 1'b1; in_valid = 1'b1; flag_clear = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clear = 1'b0;
    check(sat_flag == 1'b1, "R10 set wins over clear", 64'(sat_flag), 64'd1);
    do_clear("R10 clear");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_data = 64'h11; in_shift = 64'h01; in_size = 2'd0; in_mode = 2'd1;
    in_round = 1'b0; in_sat = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_shift = 64'h02;
    check(out_valid == 1'b1 && out_data == 64'h22, "R11 first beat", out_data, 64'h22);
    check(in_ready == 1'b0, "R11 ready low on stall", 64'(in_ready), 64'd0);
    repeat (2) @(negedge clk);
    check(out_data == 64'h22, "R11 held while stalled", out_data, 64'h22);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && out_data == 64'h44, "R11 second beat", out_data, 64'h44);
    @(negedge clk);
    check(out_valid == 1'b0, "R11 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    in_valid = 1'b0; out_ready = 1'b1; flag_clear = 1'b0;
    in_data = '0; in_shift = '0; in_size = '0; in_mode = '0;
    in_round = 1'b0; in_sat = 1'b0;
    t_reset();
    t_wrap();
    t_signed_right();
    t_unsigned_right();
    t_round();
    t_signed_sat();
    t_unsigned_sat();
    t_big_left();
    t_s2u();
    t_sticky();
    t_backpressure();
    t_size_lanes();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule